// File: doc/BRIEF.md
# DRAM Strobe-Sequence Cycle Decoder

This block sits on the memory side of an asynchronous DRAM interface. It runs on a fast sampling clock and watches the four active-low control lines: row strobe, column strobe, write enable and output enable. From the order of their edges it works out what kind of memory cycle the controller is running. It reports that cycle type as a code. It also gives one-clock strobes for when the row address and the column address should be captured.

It drives the enable for the data bus under extended-data-out rules, so read data stays on the bus after the column strobe rises. It keeps an internal refresh row counter, which column-before-row cycles use and advance. It detects a self-refresh period held by the controller, and while in self-refresh it steps the counter from an internal timer.

The block can be the control front end of a behavioural DRAM model, or it can act as a passive protocol monitor. The storage array is not part of it.

Top module: `dram_cycle_decoder`

## Requirements
- R1: When the row strobe falls while the column strobe was already low at the previous sample, the cycle type becomes CBR refresh (code 5). At that same clock edge `refresh_row` increments by one, wrapping modulo 2^ROW_W, and `row_latch` stays low.
- R2: When the row strobe falls while the column strobe is high, `row_latch` pulses high for exactly one clock. The cycle type becomes row-only refresh (code 4) and stays 4 for as long as the column strobe stays high.
- R3: A column strobe fall with the row strobe low and write enable low pulses `col_latch` for one clock and sets the type to early write (code 2). `dq_oe` then stays low for the rest of that cycle, even if output enable is low.
- R4: A column strobe fall with write enable high pulses `col_latch` and sets the type to read (code 1). If write enable then falls while the column strobe is still low, the type becomes read-modify-write (code 3) and `dq_oe` goes low.
- R5: After a read column fall, `dq_oe` is high one clock after each sample at which read data is valid, output enable is low and write enable is high. Read data stays valid after the column strobe rises while the row strobe is low. `dq_oe` drops while output enable is high and returns when it goes low again. Read data is cleared once both strobes are high together.
- R6: Each new column strobe fall inside one row strobe low period gets its own `col_latch` pulse and is classified again from write enable (page mode). A hidden refresh, where the column strobe stays low while the row strobe goes high and then low again, is a CBR refresh under R1. During it, read data stays on the bus while output enable is low.
- R7: The cycle type code is 0 idle, 1 read, 2 early write, 3 read-modify-write, 4 row-only refresh, 5 CBR refresh, 6 self-refresh. Code 7 never appears.
- R8: In a CBR cycle, once both strobes have stayed low for SELF_CYC clocks, the type becomes self-refresh (code 6). If the column strobe rises first, the type stays CBR and the hold count starts over.
- R9: Self-refresh continues whatever the column strobe level, and `refresh_row` advances by one every TICK_CYC clocks. A sampled high row strobe always gives type 0 at that edge, which ends self-refresh and every other cycle.
- R10: During and right after reset, the type is 0, both latch strobes and `dq_oe` are low, and `refresh_row` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| cycle_type | output | 3 | Current cycle classification code |
| row_latch | output | 1 | One-clock pulse to capture the row address |
| col_latch | output | 1 | One-clock pulse to capture the column address |
| dq_oe | output | 1 | Enable for driving read data onto the bus |
| refresh_row | output | ROW_W | Internal refresh row counter |

## Verification
The assertions check several rules on every clock:
- `dq_oe` is only ever driven when output enable was low and write enable high.
- An early write never drives the bus.
- The refresh row only moves in single steps.
- The two latch strobes never coincide.
- Code 7 never appears.
- Self-refresh is only reached from CBR.
- A high row strobe always returns the type to idle.

Other behaviours depend on a particular order of strobes, so only the bench's scenarios can show them:
- the choice between early write and read-modify-write;
- data held on the bus after the column strobe rises;
- counter advance during a hidden refresh;
- the self-refresh hold threshold and the timer ticks.

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder #(
  parameter int ROW_W    = 11,
  parameter int SELF_CYC = 12500,
  parameter int TICK_CYC = 1953
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic             oe_n,
  output logic [2:0]       cycle_type,
  output logic             row_latch,
  output logic             col_latch,
  output logic             dq_oe,
  output logic [ROW_W-1:0] refresh_row
);

  localparam logic [2:0] CT_IDLE  = 3'd0;
  localparam logic [2:0] CT_READ  = 3'd1;
  localparam logic [2:0] CT_EWR   = 3'd2;
  localparam logic [2:0] CT_RMW   = 3'd3;
  localparam logic [2:0] CT_RONLY = 3'd4;
  localparam logic [2:0] CT_CBR   = 3'd5;
  localparam logic [2:0] CT_SELF  = 3'd6;

  localparam int SW = (SELF_CYC > 1) ? $clog2(SELF_CYC) : 1;
  localparam int TW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;

  logic          ras_q, cas_q, we_q;
  logic          dvalid, dvalid_next;
  logic [SW-1:0] self_cnt;
  logic [TW-1:0] tick_cnt;

  wire ras_fall  = ras_q & ~ras_n;
  wire cas_fall  = cas_q & ~cas_n;
  wire we_fall   = we_q & ~we_n;
  wire in_access = (cycle_type == CT_READ) || (cycle_type == CT_EWR) ||
                   (cycle_type == CT_RMW)  || (cycle_type == CT_RONLY);

  always_comb begin
    if (ras_n && cas_n)
      dvalid_next = 1'b0;
    else if (cycle_type == CT_SELF)
      dvalid_next = 1'b0;
    else if (cas_fall && !ras_n && !ras_fall && in_access)
      dvalid_next = we_n;
    else if (!we_n)
      dvalid_next = 1'b0;
    else
      dvalid_next = dvalid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q       <= 1'b1;
      cas_q       <= 1'b1;
      we_q        <= 1'b1;
      cycle_type  <= CT_IDLE;
      row_latch   <= 1'b0;
      col_latch   <= 1'b0;
      refresh_row <= '0;
      self_cnt    <= '0;
      tick_cnt    <= '0;
      dvalid      <= 1'b0;
      dq_oe       <= 1'b0;
    end else begin
      ras_q     <= ras_n;
      cas_q     <= cas_n;
      we_q      <= we_n;
      row_latch <= 1'b0;
      col_latch <= 1'b0;
      dvalid    <= dvalid_next;
      dq_oe     <= dvalid_next & ~oe_n & we_n;
      if (ras_n) begin
        cycle_type <= CT_IDLE;
        self_cnt   <= '0;
        tick_cnt   <= '0;
      end else if (ras_fall) begin
        self_cnt <= '0;
        if (!cas_q) begin
          cycle_type  <= CT_CBR;
          refresh_row <= refresh_row + 1'b1;
        end else begin
          cycle_type <= CT_RONLY;
          row_latch  <= 1'b1;
        end
      end else begin
        case (cycle_type)
          CT_CBR: begin
            if (cas_n)
              self_cnt <= '0;
            else if (self_cnt == SW'(SELF_CYC - 1)) begin
              cycle_type <= CT_SELF;
              tick_cnt   <= '0;
            end else
              self_cnt <= self_cnt + 1'b1;
          end
          CT_SELF: begin
            if (tick_cnt == TW'(TICK_CYC - 1)) begin
              tick_cnt    <= '0;
              refresh_row <= refresh_row + 1'b1;
            end else
              tick_cnt <= tick_cnt + 1'b1;
          end
          CT_RONLY, CT_READ, CT_EWR, CT_RMW: begin
            if (cas_fall) begin
              col_latch  <= 1'b1;
              cycle_type <= we_n ? CT_READ : CT_EWR;
            end else if (we_fall && !cas_n && cycle_type == CT_READ)
              cycle_type <= CT_RMW;
          end
          default: ;
        endcase
      end
    end
  end

  assert_type_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_type <= CT_SELF);

  assert_oe_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> ($past(!oe_n) && $past(we_n)));

  assert_write_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_type == CT_EWR) |-> !dq_oe);

  assert_row_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_row != $past(refresh_row)) |-> (refresh_row == $past(refresh_row) + 1'b1));

  assert_latch_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(row_latch && col_latch));

  assert_self_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_type == CT_SELF) |-> ($past(cycle_type) == CT_CBR || $past(cycle_type) == CT_SELF));

  assert_ras_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ras_n |=> (cycle_type == CT_IDLE));

endmodule

// File: tb/dram_cycle_decoder_tb.sv
module dram_cycle_decoder_tb;
  localparam int ROW_W    = 11;
  localparam int SELF_CYC = 12500;
  localparam int TICK_CYC = 1953;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [2:0]       cycle_type;
  logic             row_latch, col_latch, dq_oe;
  logic [ROW_W-1:0] refresh_row;

  int nchk = 0, nerr = 0;
  logic [ROW_W-1:0] exp_row = '0;
  bit done = 0;

  always #4 clk = ~clk;

  dram_cycle_decoder #(.ROW_W(ROW_W), .SELF_CYC(SELF_CYC), .TICK_CYC(TICK_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .cycle_type(cycle_type), .row_latch(row_latch), .col_latch(col_latch),
    .dq_oe(dq_oe), .refresh_row(refresh_row));

  function automatic int col_type(input bit we_high);
    return we_high ? 1 : 2;
  endfunction

  function automatic logic [ROW_W-1:0] next_row(input logic [ROW_W-1:0] r);
    return r + 1'b1;
  endfunction

  function automatic int exp_oe(input bit valid, input bit oe_low, input bit we_high);
    return (valid && oe_low && we_high) ? 1 : 0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input bit r, input bit c, input bit w, input bit o);
    @(negedge clk);
    ras_n = r; cas_n = c; we_n = w; oe_n = o;
    @(posedge clk);
    #1;
  endtask

  task automatic do_access(input bit early, input bit rmw, input bit oe_low);
    bit wpre = !early;
    step(1, 1, 1, 1);
    step(0, 1, wpre, !oe_low);
    chk("R2 row latch", row_latch, 1);
    chk("R2 row-only type", cycle_type, 4);
    step(0, 1, wpre, !oe_low);
    chk("R2 single pulse", row_latch, 0);
    step(0, 0, wpre, !oe_low);
    chk("R3/R4 col latch", col_latch, 1);
    chk("R3/R4 type", cycle_type, col_type(wpre));
    chk("R5 dq_oe at access", dq_oe, exp_oe(wpre, oe_low, wpre));
    if (rmw && !early) begin
      step(0, 0, 0, 1);
      chk("R4 rmw type", cycle_type, 3);
      chk("R4 rmw bus off", dq_oe, 0);
      step(0, 1, 1, !oe_low);
      chk("R4 rmw stays off", dq_oe, 0);
    end else begin
      step(0, 1, 1, !oe_low);
      chk("R3/R5 after cas rise", dq_oe, exp_oe(wpre, oe_low, 1));
      if (!early && oe_low) begin
        step(0, 1, 1, 1);
        chk("R5 oe high off", dq_oe, 0);
        step(0, 1, 1, 0);
        chk("R5 oe low again", dq_oe, 1);
      end
    end
    step(1, 1, 1, 0);
    chk("R9 idle at ras high", cycle_type, 0);
    chk("R5 both high off", dq_oe, 0);
  endtask

  task automatic do_cbr();
    step(1, 1, 1, 1);
    step(1, 0, 1, 1);
    chk("R1 pre type", cycle_type, 0);
    step(0, 0, 1, 1);
    exp_row = next_row(exp_row);
    chk("R1 cbr type", cycle_type, 5);
    chk("R1 row advance", refresh_row, exp_row);
    chk("R1 no row latch", row_latch, 0);
    step(1, 1, 1, 1);
  endtask

  task automatic do_ronly(input int len);
    step(1, 1, 1, 1);
    step(0, 1, 1, 1);
    chk("R2 row latch", row_latch, 1);
    for (int i = 0; i < len; i++) step(0, 1, $urandom_range(0, 1), 1);
    chk("R2 row-only held", cycle_type, 4);
    chk("R2 no col latch", col_latch, 0);
    chk("R1 row unchanged", refresh_row, exp_row);
    step(1, 1, 1, 1);
  endtask

  task automatic do_hidden();
    step(1, 1, 1, 1);
    step(0, 1, 1, 0);
    step(0, 0, 1, 0);
    chk("R5 read data", dq_oe, 1);
    step(1, 0, 1, 0);
    chk("R6 hidden ras high idle", cycle_type, 0);
    chk("R6 hidden data held", dq_oe, 1);
    step(0, 0, 1, 0);
    exp_row = next_row(exp_row);
    chk("R6 hidden cbr", cycle_type, 5);
    chk("R6 hidden row", refresh_row, exp_row);
    chk("R6 hidden data on", dq_oe, 1);
    step(1, 1, 1, 0);
    chk("R5 off after both high", dq_oe, 0);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    void'($urandom(7));
    #1;
    chk("R10 reset type", cycle_type, 0);
    chk("R10 reset dq_oe", dq_oe, 0);
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset row", refresh_row, 0);
    chk("R10 reset latches", row_latch | col_latch, 0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1, 1, 1, 1);
    chk("R10 after release", cycle_type, 0);

    do_access(0, 0, 1);
    do_access(1, 0, 1);
    do_access(0, 1, 1);
    do_ronly(5);
    do_cbr();
    do_hidden();

    step(1, 1, 1, 1);
    step(0, 1, 1, 0);
    step(0, 0, 1, 0);
    chk("R6 page first read", cycle_type, 1);
    step(0, 1, 0, 0);
    step(0, 0, 0, 0);
    chk("R6 page second col latch", col_latch, 1);
    chk("R6 page second early write", cycle_type, 2);
    chk("R3 page write quiet", dq_oe, 0);
    step(0, 1, 1, 0);
    step(0, 0, 1, 0);
    chk("R6 page third read", cycle_type, 1);
    step(1, 1, 1, 1);

    step(1, 0, 1, 1);
    step(0, 0, 1, 1);
    exp_row = next_row(exp_row);
    repeat (SELF_CYC / 2) step(0, 0, 1, 1);
    step(0, 1, 1, 1);
    repeat (SELF_CYC / 2 + 100) step(0, 0, 1, 1);
    chk("R8 cas rise restarts hold", cycle_type, 5);
    step(1, 1, 1, 1);

    for (int it = 0; it < 150; it++) begin
      int k = $urandom_range(0, 5);
      bit o = 1'($urandom_range(0, 1));
      case (k)
        0: do_access(0, 0, o);
        1: do_access(1, 0, o);
        2: do_access(0, 1, o);
        3: do_ronly($urandom_range(1, 6));
        4: do_cbr();
        default: do_hidden();
      endcase
      repeat ($urandom_range(0, 3)) step(1, 1, 1, 1);
    end

    step(1, 1, 1, 1);
    step(1, 0, 1, 1);
    step(0, 0, 1, 1);
    exp_row = next_row(exp_row);
    repeat (SELF_CYC - 20) step(0, 0, 1, 1);
    chk("R8 below threshold", cycle_type, 5);
    repeat (40) step(0, 0, 1, 1);
    chk("R8 self entered", cycle_type, 6);
    repeat (2 * TICK_CYC + 100) step(0, 1, 1, 0);
    chk("R9 self with cas high", cycle_type, 6);
    chk("R9 self bus off", dq_oe, 0);
    exp_row = next_row(next_row(exp_row));
    chk("R9 timer advance", refresh_row, exp_row);
    step(1, 1, 1, 1);
    chk("R9 exit on ras high", cycle_type, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule